// File: doc/BRIEF.md
# MDIO PHY Address Discovery Scanner

This sequencer locates the first PHY that answers on a management (MDIO) bus and captures its 32-bit identifier. On a start pulse it walks the 32 PHY addresses from the lowest upward. At each address it issues a read of identifier register 1 through an external MDIO master, using a request, address and register fields, a done strobe and read data. A read of all ones means nothing is attached there. The first address that returns anything else is taken as the PHY. Identifier register 2 is then read at that same address, and the two halves are joined into one identifier.

If a whole sweep of the bus finds nothing, the scanner idles for a programmable number of clock cycles and sweeps again. This gives slow devices time to leave reset. The number of sweeps is capped. The identifier is compared against a small parameter table of known devices, and a PHY that is not in the table is still reported as found. A one-cycle done pulse closes every search. Once a PHY has been found, later starts return the stored result at once and issue no bus traffic.

Top module: `mdio_phy_finder`

## Requirements
- R1: After a start pulse in idle, the first request asks for PHY address 0. Requests visit addresses 0 to 31 in ascending order within a sweep, and every probe targets register 2 (identifier 1).
- R2: `mdio_req` stays high with `mdio_phy_addr` and `mdio_reg_addr` stable until the cycle in which `mdio_done` is high. A following probe is presented in the very next cycle.
- R3: A register-2 read returning 16'hFFFF moves the scan to the next address. The first register-2 read returning any other value stops the sweep and is followed by a register-3 read at the same address.
- R4: After the register-3 read completes, `scan_done` pulses for one cycle in the next cycle. At that point `phy_found`=1, `not_found`=0, `phy_addr` holds the responding address, and `phy_id` = {register-2 value, register-3 value}.
- R5: When a sweep other than the last ends with no response, `mdio_req` stays low for exactly WAIT_CYCLES cycles. The next sweep then starts again at address 0.
- R6: After MAX_PASSES sweeps with no response, `scan_done` pulses with `not_found`=1, `phy_found`=0, `id_known`=0, `phy_id`=0 and `phy_addr`=5'h1F.
- R7: `id_known`=1 only when `phy_id` equals a table entry that is nonzero and that comes before the first zero entry. Entry i sits at bits [32*i+31:32*i] of KNOWN_IDS. Any other identifier is reported as found with `id_known`=0.
- R8: A start while `phy_found`=1 issues no request. It pulses `scan_done` in the next cycle and leaves all result outputs unchanged.
- R9: While reset is applied and after it is released, `mdio_req`, `scan_done`, `phy_found`, `id_known` and `not_found` are 0, `phy_id` is 0 and `phy_addr` is 5'h1F.
- R10: A start pulse during a scan has no effect on the request sequence or on the result.
- R11: A start after a not-found result runs a fresh scan from address 0, sweep 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (single-cycle pulse) |
| mdio_req | output | 1 | Read request to the MDIO master |
| mdio_phy_addr | output | 5 | PHY address of the request |
| mdio_reg_addr | output | 5 | Register number of the request |
| mdio_done | input | 1 | Read completed, data valid this cycle |
| mdio_rdata | input | 16 | Read data from the MDIO master |
| phy_addr | output | 5 | Found address, all ones when none |
| phy_found | output | 1 | A PHY has been identified |
| phy_id | output | 32 | Combined identifier |
| id_known | output | 1 | Identifier is in the known table |
| not_found | output | 1 | Search ended without a response |
| scan_done | output | 1 | One-cycle end-of-search pulse |

## Verification
A new request is due one cycle after the start edge or after the previous `mdio_done` edge. `scan_done` and the result outputs are due one cycle after the final `mdio_done`, or one cycle after start when a stored result is returned. Between sweeps, `mdio_req` is low for exactly WAIT_CYCLES cycles. The bench samples on the falling edge and keeps a queue of the expected address and register pairs, built from its own PHY population model. Every completed read is checked against the head of that queue. The low-request gaps are counted, and at the done pulse the bench checks that the previous sampled cycle carried `mdio_done`.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2 * DATA_W;

    localparam logic [REG_AW-1:0] REG_ID_HI  = 5'd2;
    localparam logic [REG_AW-1:0] REG_ID_LO  = 5'd3;
    localparam logic [DATA_W-1:0] NO_DEVICE  = 16'hFFFF;
    localparam logic [PHY_AW-1:0] LAST_PROBE = '1;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ID_HI,
        S_ID_LO,
        S_GAP
    } scan_st_e;
endpackage

// File: rtl/phy_gap_timer.sv
module phy_gap_timer #(
    parameter int WAIT_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST)); // R5
endmodule

// File: rtl/phy_id_match.sv
module phy_id_match #(
    parameter int NUM_IDS = 4,
    parameter logic [NUM_IDS*32-1:0] KNOWN_IDS = '0
) (
    input  logic [31:0] cand,
    output logic        hit
);
    logic [NUM_IDS:0]   live;
    logic [NUM_IDS-1:0] eq;

    assign live[0] = 1'b1;

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_entry
        localparam logic [31:0] ENTRY = KNOWN_IDS[32*i +: 32];
        assign live[i+1] = live[i] && (ENTRY != 32'h0);
        assign eq[i]     = live[i+1] && (cand == ENTRY);
    end

    assign hit = |eq;
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
    import phy_scan_pkg::*;
#(
    parameter int MAX_PASSES = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mdio_done,
    input  logic [DATA_W-1:0] mdio_rdata,
    input  logic              gap_over,
    input  logic              cand_known,
    output logic [ID_W-1:0]   cand_id,
    output logic              in_gap,
    output logic              mdio_req,
    output logic [PHY_AW-1:0] mdio_phy_addr,
    output logic [REG_AW-1:0] mdio_reg_addr,
    output logic [PHY_AW-1:0] phy_addr,
    output logic              phy_found,
    output logic [ID_W-1:0]   phy_id,
    output logic              id_known,
    output logic              not_found,
    output logic              scan_done
);
    localparam int PASS_W = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1;
    localparam logic [PASS_W-1:0] FINAL_PASS = PASS_W'(MAX_PASSES - 1);

    typedef struct packed {
        scan_st_e          st;
        logic [PHY_AW-1:0] probe;
        logic [PASS_W-1:0] pass;
        logic [DATA_W-1:0] hi;
        logic [PHY_AW-1:0] res_addr;
        logic              found;
        logic [ID_W-1:0]   id;
        logic              known;
        logic              nf;
        logic              done;
    } seq_t;

    seq_t q, d;

    localparam seq_t RESET_VAL = '{st: S_IDLE, probe: '0, pass: '0, hi: '0,
                                   res_addr: '1, found: 1'b0, id: '0,
                                   known: 1'b0, nf: 1'b0, done: 1'b0};

    assign cand_id = {q.hi, mdio_rdata};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    if (q.found) begin
                        d.done = 1'b1;
                    end else begin
                        d.st       = S_ID_HI;
                        d.probe    = '0;
                        d.pass     = '0;
                        d.nf       = 1'b0;
                        d.known    = 1'b0;
                        d.id       = '0;
                        d.res_addr = '1;
                    end
                end
            end
            S_ID_HI: begin
                if (mdio_done) begin
                    if (mdio_rdata == NO_DEVICE) begin
                        if (q.probe != LAST_PROBE) begin
                            d.probe = q.probe + 1'b1;
                        end else if (q.pass == FINAL_PASS) begin
                            d.nf   = 1'b1;
                            d.done = 1'b1;
                            d.st   = S_IDLE;
                        end else begin
                            d.pass = q.pass + 1'b1;
                            d.st   = S_GAP;
                        end
                    end else begin
                        d.hi = mdio_rdata;
                        d.st = S_ID_LO;
                    end
                end
            end
            S_ID_LO: begin
                if (mdio_done) begin
                    d.id       = cand_id;
                    d.known    = cand_known;
                    d.found    = 1'b1;
                    d.res_addr = q.probe;
                    d.done     = 1'b1;
                    d.st       = S_IDLE;
                end
            end
            S_GAP: begin
                if (gap_over) begin
                    d.probe = '0;
                    d.st    = S_ID_HI;
                end
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign in_gap        = (q.st == S_GAP);
    assign mdio_req      = (q.st == S_ID_HI) || (q.st == S_ID_LO);
    assign mdio_phy_addr = q.probe;
    assign mdio_reg_addr = (q.st == S_ID_LO) ? REG_ID_LO : REG_ID_HI;
    assign phy_addr      = q.res_addr;
    assign phy_found     = q.found;
    assign phy_id        = q.id;
    assign id_known      = q.known;
    assign not_found     = q.nf;
    assign scan_done     = q.done;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_phy_addr) && $stable(mdio_reg_addr))); // R2
    AST_NEXT_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_reg_addr == REG_ID_HI && mdio_done && mdio_rdata == NO_DEVICE
         && mdio_phy_addr != LAST_PROBE)
        |=> (mdio_req && mdio_phy_addr == PHY_AW'($past(mdio_phy_addr) + 1'b1))); // R3
    AST_SAME_ADDR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && mdio_reg_addr == REG_ID_HI && mdio_done && mdio_rdata != NO_DEVICE)
        |=> (mdio_req && mdio_reg_addr == REG_ID_LO && $stable(mdio_phy_addr))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done); // R4
    AST_NF_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> (phy_addr == '1 && !phy_found && !id_known)); // R6
    AST_KNOWN_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        id_known |-> phy_found); // R7
    AST_STORED_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mdio_req && !in_gap && start && phy_found) |=> (scan_done && !mdio_req && $stable(phy_id))); // R8
endmodule

// File: rtl/mdio_phy_finder.sv
module mdio_phy_finder
    import phy_scan_pkg::*;
#(
    parameter int MAX_PASSES  = 11,
    parameter int WAIT_CYCLES = 1000000,
    parameter int NUM_IDS     = 4,
    parameter logic [NUM_IDS*32-1:0] KNOWN_IDS = {32'h0, 32'h0, 32'h00406322, 32'h0022561B}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        mdio_req,
    output logic [4:0]  mdio_phy_addr,
    output logic [4:0]  mdio_reg_addr,
    input  logic        mdio_done,
    input  logic [15:0] mdio_rdata,
    output logic [4:0]  phy_addr,
    output logic        phy_found,
    output logic [31:0] phy_id,
    output logic        id_known,
    output logic        not_found,
    output logic        scan_done
);
    logic          gap_run;
    logic          gap_over;
    logic          cand_known;
    logic [31:0]   cand_id;

    phy_gap_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .expired (gap_over)
    );

    phy_id_match #(.NUM_IDS(NUM_IDS), .KNOWN_IDS(KNOWN_IDS)) u_match (
        .cand (cand_id),
        .hit  (cand_known)
    );

    phy_scan_seq #(.MAX_PASSES(MAX_PASSES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .mdio_done     (mdio_done),
        .mdio_rdata    (mdio_rdata),
        .gap_over      (gap_over),
        .cand_known    (cand_known),
        .cand_id       (cand_id),
        .in_gap        (gap_run),
        .mdio_req      (mdio_req),
        .mdio_phy_addr (mdio_phy_addr),
        .mdio_reg_addr (mdio_reg_addr),
        .phy_addr      (phy_addr),
        .phy_found     (phy_found),
        .phy_id        (phy_id),
        .id_known      (id_known),
        .not_found     (not_found),
        .scan_done     (scan_done)
    );

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        gap_run |-> !mdio_req); // R5
endmodule

// File: tb/test_mdio_phy_finder.sv
`timescale 1ns/1ps
module test_mdio_phy_finder;
    localparam int WAITC  = 20;
    localparam int PASSES = 11;
    localparam int LAT    = 2;

    logic        clk = 0, rst_n = 0, start = 0, mdio_done = 0;
    logic [15:0] mdio_rdata = 0;
    logic        mdio_req, phy_found, id_known, not_found, scan_done;
    logic [4:0]  mdio_phy_addr, mdio_reg_addr, phy_addr;
    logic [31:0] phy_id;

    mdio_phy_finder #(.MAX_PASSES(PASSES), .WAIT_CYCLES(WAITC), .NUM_IDS(4),
        .KNOWN_IDS({32'h12345678, 32'h0, 32'h00406322, 32'h0022561B})) i_mdio_phy_finder (
        .clk(clk), .rst_n(rst_n), .start(start), .mdio_req(mdio_req),
        .mdio_phy_addr(mdio_phy_addr), .mdio_reg_addr(mdio_reg_addr),
        .mdio_done(mdio_done), .mdio_rdata(mdio_rdata), .phy_addr(phy_addr),
        .phy_found(phy_found), .phy_id(phy_id), .id_known(id_known),
        .not_found(not_found), .scan_done(scan_done));

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // PHY population model
    int          pa[2], pw[2];
    logic [31:0] pid[2];
    int          pass_seen;

    function automatic bit present(int a, int p);
        for (int i = 0; i < 2; i++)
            if (pa[i] == a && p >= pw[i]) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] id_at(int a);
        for (int i = 0; i < 2; i++)
            if (pa[i] == a) return pid[i];
        return 32'hFFFFFFFF;
    endfunction

    // Expected results
    int          exp_q[$];
    int          e_addr, e_gaps, gaps;
    bit          e_found, e_known, e_nf;
    logic [31:0] e_id;

    function automatic void plan();
        bit hit = 0;
        exp_q.delete();
        e_addr = 31; e_found = 0; e_id = 0; e_known = 0; e_nf = 1; e_gaps = 0;
        for (int p = 1; p <= PASSES && !hit; p++) begin
            if (p > 1) e_gaps++;
            for (int a = 0; a < 32; a++) begin
                exp_q.push_back(a * 8 + 2);
                if (present(a, p)) begin
                    exp_q.push_back(a * 8 + 3);
                    hit = 1; e_addr = a; e_found = 1; e_nf = 0; e_id = id_at(a);
                    e_known = (e_id == 32'h0022561B) || (e_id == 32'h00406322);
                    break;
                end
            end
        end
        gaps = 0;
        pass_seen = 0;
    endfunction

    // Responder and monitor, all on the falling edge
    bit   busy = 0, prev_req = 0, prev_done = 0;
    int   cnt = 0, gap_run = 0;
    logic [4:0] prev_a, prev_r;

    always @(negedge clk) begin
        if (!rst_n) begin
            mdio_done = 0; cnt = 0; gap_run = 0;
        end else begin
            if (mdio_req && prev_req && !prev_done)
                chk(mdio_phy_addr == prev_a && mdio_reg_addr == prev_r, "R2", "fields held",
                    {mdio_phy_addr, mdio_reg_addr}, {prev_a, prev_r});
            if (busy && !mdio_req && !scan_done) gap_run++;
            if (mdio_req && gap_run > 0) begin
                chk(gap_run == WAITC, "R5", "gap length", gap_run, WAITC);
                gaps++;
                gap_run = 0;
            end
            if (mdio_done) begin
                mdio_done = 0; cnt = 0;
            end else if (mdio_req) begin
                cnt++;
                if (cnt == LAT) begin
                    int e;
                    if (mdio_phy_addr == 0 && mdio_reg_addr == 2) pass_seen++;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                    chk(busy && e == int'(mdio_phy_addr) * 8 + int'(mdio_reg_addr), "R1/R3",
                        "request addr*8+reg", int'(mdio_phy_addr) * 8 + int'(mdio_reg_addr), e);
                    if (mdio_reg_addr == 2)
                        mdio_rdata = present(mdio_phy_addr, pass_seen) ? id_at(mdio_phy_addr) >> 16 : 16'hFFFF;
                    else
                        mdio_rdata = id_at(mdio_phy_addr) & 32'hFFFF;
                    mdio_done = 1;
                end
            end
            if (scan_done && busy) begin
                chk(prev_done, "R4", "done one cycle after last read", 0, 1);
                chk(exp_q.size() == 0, "R1", "requests left", exp_q.size(), 0);
                chk(gaps == e_gaps, "R5", "gap count", gaps, e_gaps);
                chk(phy_found == e_found, e_nf ? "R6" : "R4", "phy_found", phy_found, e_found);
                chk(not_found == e_nf, "R6", "not_found", not_found, e_nf);
                chk(phy_addr == 5'(e_addr), e_nf ? "R6" : "R4", "phy_addr", phy_addr, e_addr);
                chk(phy_id == e_id, "R4", "phy_id", phy_id, e_id);
                chk(id_known == e_known, "R7", "id_known", id_known, e_known);
                busy = 0;
            end
            chk(!(phy_found && not_found), "R6", "found and not_found together", 1, 0);
        end
        prev_req = mdio_req; prev_done = mdio_done;
        prev_a = mdio_phy_addr; prev_r = mdio_reg_addr;
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        #0.5;
        chk(!mdio_req && !scan_done && !phy_found && !id_known && !not_found, "R9",
            "reset flags", {mdio_req, scan_done, phy_found, id_known, not_found}, 0);
        chk(phy_addr == 5'h1F && phy_id == 0, "R9", "reset result", {phy_addr, phy_id}, {5'h1F, 32'h0});
        rst_n = 1;
        @(negedge clk);
        #0.5;
        chk(!mdio_req && phy_addr == 5'h1F && !scan_done, "R9", "after release",
            {mdio_req, phy_addr}, {1'b0, 5'h1F});
    endtask

    task automatic kick();
        @(negedge clk);
        start = 1;
        @(posedge clk);
        #1 start = 0;
        busy = 1;
    endtask

    task automatic finish_scan();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic stored_return();
        logic [31:0] id0 = phy_id;
        logic [4:0]  a0  = phy_addr;
        bit          k0  = id_known;
        @(negedge clk);
        start = 1;
        @(posedge clk);
        #1 start = 0;
        @(negedge clk);
        #0.5;
        chk(scan_done == 1, "R8", "immediate done", scan_done, 1);
        for (int i = 0; i < 5; i++) begin
            chk(!mdio_req, "R8", "no request", mdio_req, 0);
            @(negedge clk);
            #0.5;
        end
        chk(phy_id == id0 && phy_addr == a0 && id_known == k0 && phy_found, "R8", "result kept",
            {phy_addr, phy_id}, {a0, id0});
    endtask

    initial begin
        #(200000 * 5);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        if (!finished) $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // A: one known PHY at 5, awake from the first sweep
        pa = '{5, -1}; pw = '{1, 1}; pid = '{32'h0022561B, 32'h0};
        do_reset();
        plan(); kick(); finish_scan();
        stored_return();

        // B: PHY at the last address, wakes in sweep 3
        pa = '{31, -1}; pw = '{3, 1}; pid = '{32'h00406322, 32'h0};
        do_reset();
        plan(); kick(); finish_scan();

        // C: two PHYs, lowest wins; its id sits behind the zero terminator; start mid-scan ignored (R10)
        pa = '{9, 7}; pw = '{1, 1}; pid = '{32'hAAAA0001, 32'h12345678};
        do_reset();
        plan(); kick();
        repeat (6) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        finish_scan();

        // D: nothing on the bus, every sweep runs out
        pa = '{-1, -1};
        do_reset();
        plan(); kick(); finish_scan();

        // E: restart after not-found runs a fresh scan (R11)
        pa = '{2, -1}; pw = '{1, 1}; pid = '{32'h01410CC2, 32'h0};
        plan(); kick(); finish_scan();
        chk(phy_found && phy_addr == 5'd2, "R11", "rescan result", phy_addr, 2);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule